// File: doc/BRIEF.md
# Three-Personality Bank Mode Switcher

This block sits on a cartridge board whose bank controller can behave as one of three bank-switching personalities. The first uses nibble-wide bank registers. The second has a scanline interrupt. The third loads its registers serially, one bit per write. A small mode register, written by the CPU in the expansion area below the program ROM window, picks the active personality. The block then routes that personality's bank numbers to the board's PRG and CHR bank outputs.

The register files of the three personalities live outside the block. Each one presents its current bank numbers for the access in progress. The switcher does three things with them:

- It limits each bank number to the granularity of the active personality.
- It places mode bit 2 above the CHR bank as a high-bank select.
- It fills the low bits of coarse banks from the CPU and PPU address lines.

The PRG output is always an 8 KB bank number and the CHR output is always a 1 KB bank number. The mirroring output is chosen in the same way as the banks.

When the selection changes, the block pulses an activation strobe toward the newly chosen personality. The first time each personality is chosen after reset, it also pulses an initialization strobe. On that strobe the nibble personality loads 0xF into all sixteen CHR nibble registers. The serial personality clears itself and takes an internal reset write, meaning a data byte with bit 7 set.

Top module: `tri_mode_bank_switch`

## Requirements
- R1: A write loads `mode_data` into the mode register only when `wr_addr` lies in 0x4020..0x5FFF and `wr_addr[8]` is 1. Any other write leaves the mode register and all outputs unchanged.
- R2: Mode bits [1:0] choose the personality: 0 selects nibble, 1 selects scanline-IRQ, and 2 or 3 select serial.
- R3: In the nibble and scanline-IRQ modes, `chr_bank` is {mode bit 2, the personality's 8-bit 1 KB bank}.
- R4: In the nibble and scanline-IRQ modes, `prg_bank` is the personality's 6-bit bank. In serial mode, `prg_bank` is {`ser_prg` (16 KB units, 5 bits), `cpu_a13`}.
- R5: In serial mode, `chr_bank` is {mode bit 2, `ser_chr` (4 KB units, 6 bits), `ppu_a11`, `ppu_a10`}.
- R6: Reset clears the mode register and marks all three personalities as uninitialized. In the first cycle after reset is released, `act_strobe` and `init_strobe` both read 3'b001. Bit k of either strobe stands for personality k: 0 nibble, 1 IRQ, 2 serial.
- R7: A decoded write that changes mode bits [1:0] raises, in the next cycle, the `act_strobe` bit of the newly selected personality. The matching `init_strobe` bit is raised as well if that personality has not been initialized since reset; after that it is never raised again until the next reset.
- R8: A decoded write that leaves mode bits [1:0] unchanged raises no strobe. From the next cycle on, the bank outputs reflect the new mode bit 2.
- R9: `mirror` encodes 0 as single-screen lower, 1 as single-screen upper, 2 as vertical and 3 as horizontal. In serial mode it equals `ser_mirror`. In the other two modes it is 2 when the personality's mirroring bit is 0 and 3 when that bit is 1.
- R10: Each strobe lasts exactly one cycle, and at most one bit of each strobe vector is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write in progress this cycle |
| wr_addr | input | 16 | CPU write address |
| mode_data | input | 3 | CPU data bits 2..0 of the write |
| nib_prg | input | 6 | Nibble personality 8 KB PRG bank |
| nib_chr | input | 8 | Nibble personality 1 KB CHR bank |
| nib_mirror | input | 1 | Nibble personality mirroring bit |
| irq_prg | input | 6 | Scanline-IRQ personality 8 KB PRG bank |
| irq_chr | input | 8 | Scanline-IRQ personality 1 KB CHR bank |
| irq_mirror | input | 1 | Scanline-IRQ personality mirroring bit |
| ser_prg | input | 5 | Serial personality 16 KB PRG bank |
| ser_chr | input | 6 | Serial personality 4 KB CHR bank |
| ser_mirror | input | 2 | Serial personality mirroring code |
| cpu_a13 | input | 1 | CPU address bit 13 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_a10 | input | 1 | PPU address bit 10 |
| prg_bank | output | 6 | Resulting 8 KB PRG bank |
| chr_bank | output | 9 | Resulting 1 KB CHR bank |
| mirror | output | 2 | Resulting mirroring code |
| act_strobe | output | 3 | One-cycle activation pulse per personality |
| init_strobe | output | 3 | One-cycle first-use initialization pulse per personality |

## Verification
The bench builds the block with its default widths: a 6-bit PRG bank, a 9-bit CHR bank and a 3-bit mode field. At these widths every mode value, and every 8-bit input pattern under each mode, can be swept exhaustively, along with every address from 0x3F00 to 0x6100 and a coarse stride across the rest of the map. A running model of the mode register and the three pending-initialization flags predicts every strobe. That model exercises each transition between personalities, including the switch between serial codes 2 and 3. A second reset then shows that the initialization flags are restored.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int NUM_PERS = 3;

  typedef enum logic [1:0] {
    PERS_NIB = 2'd0,
    PERS_IRQ = 2'd1,
    PERS_SER = 2'd2
  } pers_e;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  function automatic pers_e pers_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return PERS_NIB;
      2'd1:    return PERS_IRQ;
      default: return PERS_SER;
    endcase
  endfunction
endpackage

// File: rtl/tms_mode_ctrl.sv
module tms_mode_ctrl
  import tms_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MODE_W  = 3,
  parameter int WIN_LO  = 'h4020,
  parameter int WIN_HI  = 'h5FFF,
  parameter int SEL_BIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [MODE_W-1:0]   mode_data,
  output logic [MODE_W-1:0]   mode_o,
  output logic [NUM_PERS-1:0] act_o,
  output logic [NUM_PERS-1:0] init_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_HI);

  logic [MODE_W-1:0]   mode_q, mode_nx;
  logic [NUM_PERS-1:0] pend_q, act_q, init_q, tgt;
  logic                boot_q, hit, sel_change, fire;

  assign hit        = wr_en && (wr_addr >= LO) && (wr_addr <= HI) && wr_addr[SEL_BIT];
  assign mode_nx    = hit ? mode_data : mode_q;
  assign sel_change = hit && (mode_data[1:0] != mode_q[1:0]);
  assign fire       = boot_q || sel_change;

  for (genvar k = 0; k < NUM_PERS; k++) begin : g_tgt
    assign tgt[k] = (pers_of(mode_nx[1:0]) == pers_e'(k));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      pend_q <= '1;
      boot_q <= 1'b1;
      act_q  <= '0;
      init_q <= '0;
    end else begin
      mode_q <= mode_nx;
      boot_q <= 1'b0;
      act_q  <= fire ? tgt : '0;
      init_q <= fire ? (tgt & pend_q) : '0;
      if (fire) pend_q <= pend_q & ~tgt;
    end
  end

  assign mode_o = mode_q;
  assign act_o  = act_q;
  assign init_o = init_q;

  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_q) && $onehot0(init_q));
  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != '0) && !sel_change |=> (act_q == '0));
  p_ignore_unsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[SEL_BIT]) |=> $stable(mode_q));
  p_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !wr_en) |=> (act_q == 3'b001) && (init_q == 3'b001));
  p_change_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> $onehot(act_q));
  p_init_needs_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_q & ~act_q) == '0));
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sel_change && !boot_q) |=> (act_q == '0) && (init_q == '0));
endmodule

// File: rtl/tms_bank_mux.sv
module tms_bank_mux
  import tms_pkg::*;
#(
  parameter int PRG_W = 6,
  parameter int CHR_W = 9
) (
  input  pers_e            pers,
  input  logic             hi_bit,
  input  logic [PRG_W-1:0] nib_prg,
  input  logic [CHR_W-2:0] nib_chr,
  input  logic [PRG_W-1:0] irq_prg,
  input  logic [CHR_W-2:0] irq_chr,
  input  logic [PRG_W-2:0] ser_prg,
  input  logic [CHR_W-4:0] ser_chr,
  input  logic             cpu_a13,
  input  logic [1:0]       ppu_sub,
  output logic [PRG_W-1:0] prg_o,
  output logic [CHR_W-1:0] chr_o
);
  localparam int FINE_CHR_W = CHR_W - 1;
  localparam int COARSE_W   = CHR_W - 3;

  logic [PRG_W-1:0] fine_prg, coarse_prg;
  logic [CHR_W-1:0] fine_chr, coarse_chr;

  always_comb begin
    fine_prg = (pers == PERS_IRQ) ? irq_prg : nib_prg;
    fine_chr = {hi_bit, (pers == PERS_IRQ) ? irq_chr : nib_chr};
  end

  assign coarse_prg = {ser_prg, cpu_a13};
  assign coarse_chr = {hi_bit, ser_chr[COARSE_W-1:0], ppu_sub};

  always_comb begin
    if (pers == PERS_SER) begin
      prg_o = coarse_prg;
      chr_o = coarse_chr;
    end else begin
      prg_o = fine_prg;
      chr_o = fine_chr[FINE_CHR_W:0];
    end
  end
endmodule

// File: rtl/tms_mirror_sel.sv
module tms_mirror_sel
  import tms_pkg::*;
(
  input  pers_e      pers,
  input  logic       nib_bit,
  input  logic       irq_bit,
  input  logic [1:0] ser_code,
  output mirror_e    mirror_o
);
  always_comb begin
    unique case (pers)
      PERS_NIB: mirror_o = nib_bit ? MIR_HORZ : MIR_VERT;
      PERS_IRQ: mirror_o = irq_bit ? MIR_HORZ : MIR_VERT;
      default:  mirror_o = mirror_e'(ser_code);
    endcase
  end
endmodule

// File: rtl/tri_mode_bank_switch.sv
module tri_mode_bank_switch
  import tms_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MODE_W = 3,
  parameter int PRG_W  = 6,
  parameter int CHR_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic [PRG_W-1:0]  nib_prg,
  input  logic [CHR_W-2:0]  nib_chr,
  input  logic              nib_mirror,
  input  logic [PRG_W-1:0]  irq_prg,
  input  logic [CHR_W-2:0]  irq_chr,
  input  logic              irq_mirror,
  input  logic [PRG_W-2:0]  ser_prg,
  input  logic [CHR_W-4:0]  ser_chr,
  input  logic [1:0]        ser_mirror,
  input  logic              cpu_a13,
  input  logic              ppu_a11,
  input  logic              ppu_a10,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic [1:0]        mirror,
  output logic [2:0]        act_strobe,
  output logic [2:0]        init_strobe
);
  logic [MODE_W-1:0] mode;
  pers_e             pers;
  mirror_e           mir;

  tms_mode_ctrl #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .mode_data(mode_data), .mode_o(mode), .act_o(act_strobe), .init_o(init_strobe)
  );

  assign pers = pers_of(mode[1:0]);

  tms_bank_mux #(.PRG_W(PRG_W), .CHR_W(CHR_W)) u_mux (
    .pers(pers), .hi_bit(mode[2]),
    .nib_prg(nib_prg), .nib_chr(nib_chr), .irq_prg(irq_prg), .irq_chr(irq_chr),
    .ser_prg(ser_prg), .ser_chr(ser_chr), .cpu_a13(cpu_a13),
    .ppu_sub({ppu_a11, ppu_a10}), .prg_o(prg_bank), .chr_o(chr_bank)
  );

  tms_mirror_sel u_mir (
    .pers(pers), .nib_bit(nib_mirror), .irq_bit(irq_mirror),
    .ser_code(ser_mirror), .mirror_o(mir)
  );

  assign mirror = mir;

  p_ser_prg_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pers == PERS_SER) |-> (prg_bank[0] == cpu_a13));
  p_ser_chr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pers == PERS_SER) |-> (chr_bank[1:0] == {ppu_a11, ppu_a10}));
  p_chr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_bank[CHR_W-1] == mode[2]);
  p_fine_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pers != PERS_SER) |-> mirror[1]);
endmodule

// File: tb/test_tri_mode_bank_switch.sv
module test_tri_mode_bank_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [2:0] mode_data = '0;
  logic [5:0] nib_prg = '0, irq_prg = '0;
  logic [7:0] nib_chr = '0, irq_chr = '0;
  logic nib_mirror = 1'b0, irq_mirror = 1'b0;
  logic [4:0] ser_prg = '0;
  logic [5:0] ser_chr = '0;
  logic [1:0] ser_mirror = '0;
  logic cpu_a13 = 1'b0, ppu_a11 = 1'b0, ppu_a10 = 1'b0;
  logic [5:0] prg_bank;
  logic [8:0] chr_bank;
  logic [1:0] mirror;
  logic [2:0] act_strobe, init_strobe;

  int n_chk = 0, n_fail = 0;
  int mdl_mode = 0;
  int mdl_pend = 7;

  always #10 clk = ~clk;

  tri_mode_bank_switch i_tri_mode_bank_switch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .mode_data(mode_data),
    .nib_prg(nib_prg), .nib_chr(nib_chr), .nib_mirror(nib_mirror),
    .irq_prg(irq_prg), .irq_chr(irq_chr), .irq_mirror(irq_mirror),
    .ser_prg(ser_prg), .ser_chr(ser_chr), .ser_mirror(ser_mirror),
    .cpu_a13(cpu_a13), .ppu_a11(ppu_a11), .ppu_a10(ppu_a10),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror),
    .act_strobe(act_strobe), .init_strobe(init_strobe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pers_num(input int m);
    return ((m % 4) >= 2) ? 2 : (m % 4);
  endfunction

  // mirror settings that reveal the personality: nibble->2, irq->3, serial->0
  task automatic probe_inputs();
    nib_mirror = 1'b0; irq_mirror = 1'b1; ser_mirror = 2'd0;
  endtask

  function automatic int pers_seen(input int mir);
    return (mir == 2) ? 0 : (mir == 3) ? 1 : 2;
  endfunction

  task automatic do_write(input int addr, input int d);
    int hit, exp_act, exp_init;
    @(negedge clk);
    chk("R10 strobes idle", act_strobe * 8 + init_strobe, 0);
    probe_inputs();
    wr_en = 1'b1; wr_addr = 16'(addr); mode_data = 3'(d);
    hit = (addr >= 'h4020 && addr <= 'h5FFF && ((addr / 256) % 2) == 1) ? 1 : 0;
    exp_act = 0; exp_init = 0;
    if (hit == 1) begin
      if ((d % 4) != (mdl_mode % 4)) begin
        exp_act = 1 << pers_num(d);
        exp_init = exp_act & mdl_pend;
        mdl_pend = mdl_pend & ~exp_act;
      end
      mdl_mode = d % 8;
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1/R2 personality", pers_seen(mirror), pers_num(mdl_mode));
    chk("R1/R8 mode bit2", chr_bank / 256, mdl_mode / 4);
    chk("R7/R8 act strobe", act_strobe, exp_act);
    chk("R7 init strobe", init_strobe, exp_init);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 no strobe in reset", act_strobe * 8 + init_strobe, 0);
    rst_n = 1'b1;
    mdl_mode = 0; mdl_pend = 6;
    @(negedge clk);
    probe_inputs();
    #1;
    chk("R6 boot act", act_strobe, 1);
    chk("R6 boot init", init_strobe, 1);
    chk("R6 mode cleared pers", pers_seen(mirror), 0);
    chk("R6 mode cleared bit2", chr_bank / 256, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    probe_inputs();
    do_reset();
    // R7: walk personalities and the serial code pair
    do_write('h4100, 1);
    do_write('h4100, 2);
    do_write('h4100, 3);
    do_write('h4100, 0);
    do_write('h4100, 4);  // R8: bit2 only
    do_write('h4100, 5);
    // R1: near-exhaustive decode sweep
    for (int a = 'h3F00; a <= 'h6100; a++) do_write(a, (a * 5 + 3) % 8);
    for (int a = 0; a < 'h10000; a += 'h0101) do_write(a, (a / 7) % 8);
    // R3 R4 R5 R9: exhaustive over mode and 8-bit pattern
    for (int m = 0; m < 8; m++) begin
      do_write('h5F00, m);
      for (int v = 0; v < 256; v++) begin
        int p, eprg, echr, emir, sp, sc, a13, sub;
        @(negedge clk);
        nib_prg = 6'(v); nib_chr = 8'(v ^ 'h5A);
        irq_prg = 6'(v ^ 'hC3); irq_chr = 8'(255 - v);
        sp = (v + 7) % 32; sc = (v ^ 'h99) % 64;
        ser_prg = 5'(sp); ser_chr = 6'(sc);
        nib_mirror = v[0]; irq_mirror = v[1]; ser_mirror = 2'(v % 4);
        a13 = (v / 4) % 2; sub = (v / 8) % 4;
        cpu_a13 = a13[0]; ppu_a11 = sub[1]; ppu_a10 = sub[0];
        #1;
        p = pers_num(m);
        if (p == 2) begin
          eprg = sp * 2 + a13;
          echr = (m / 4) * 256 + sc * 4 + sub;
          emir = v % 4;
        end else if (p == 1) begin
          eprg = (v ^ 'hC3) % 64;
          echr = (m / 4) * 256 + (255 - v);
          emir = 2 + (v / 2) % 2;
        end else begin
          eprg = v % 64;
          echr = (m / 4) * 256 + (v ^ 'h5A);
          emir = 2 + v % 2;
        end
        chk(p == 2 ? "R4 serial prg" : "R4 fine prg", prg_bank, eprg);
        chk(p == 2 ? "R5 serial chr" : "R3 fine chr", chr_bank, echr);
        chk("R9 mirror", mirror, emir);
      end
    end
    // R6: second reset restores pending flags
    do_reset();
    do_write('h4100, 2);
    do_write('h4100, 1);
    do_write('h4100, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule